// File: doc/BRIEF.md
# Stacked Register File with Frame Marker

This block holds the integer register state of a processor that gives each called procedure its own window of stacked registers. It stores 128 registers of 64 bits, each paired with a one-bit "not a thing" (NaT) flag that marks contents as invalid, for example after a speculative load is abandoned. The lowest 32 registers are global and always reachable. The upper 96 form a stacked area whose visible size is set by a frame-marker register. Any access above the current frame is reported and has no effect.

Inside the frame, a leading rotating region (a multiple of eight registers) is renamed through a base held in the frame marker. A rotate-step input moves that base by one position so that software-pipelined loops see their values shift one register per iteration. The frame marker is loaded as one word through a dedicated port and is always visible at an output. The block offers two registered read ports and one write port, and it is laid out so that the data storage maps onto block RAM.

Top module: `stkrf_top`

## Requirements
- R1: Synchronous active-high reset clears the frame marker to zero and clears every NaT flag, so a global register read after reset returns NaT 0.
- R2: Index 0 always reads as data 0 with NaT 0, and a write to index 0 changes nothing.
- R3: A read index sampled at a clock edge yields that register's data and NaT on the read outputs after that edge. A write stores data and NaT together at the edge. A read of the register being written in the same cycle returns the previous contents.
- R4: A stacked index r (32 or above) with r − 32 ≥ sof is out of frame. A read of such an index returns data 0, NaT 1 and the read's bad flag high, in the same cycle as the data. A write to such an index raises wr_bad in the cycle it is presented, and the write is dropped.
- R5: The frame-marker word is laid out with sof in bits 6..0, sol in bits 13..7, sor in bits 17..14, the general-register rename base in bits 24..18, the floating-point rename base in bits 31..25 and the predicate rename base in bits 37..32. A load makes the whole word appear on fm_out one cycle later. sol is held but does not change which registers can be reached.
- R6: The rotating size is min(8 × sor, 96). A stacked index r with r − 32 below that size reaches physical register 32 + ((r − 32 + base) mod size). Other in-frame stacked indices reach the physical register with the same number.
- R7: A rotate step decrements the general-register base modulo the rotating size, with 0 wrapping to size − 1. It leaves the base unchanged when the size is 0 and leaves every other field unchanged. A load in the same cycle takes priority over the step.
- R8: Indices 1..31 are never flagged and are never renamed, whatever the frame marker holds.
- R9: A write, read or rotate in the same cycle as a frame-marker load uses the old frame marker. The new one governs accesses from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 7 | Read port A logical index |
| rd_a_data | output | 64 | Read port A data |
| rd_a_nat | output | 1 | Read port A NaT flag |
| rd_a_bad | output | 1 | Read port A out-of-frame flag |
| rd_b_idx | input | 7 | Read port B logical index |
| rd_b_data | output | 64 | Read port B data |
| rd_b_nat | output | 1 | Read port B NaT flag |
| rd_b_bad | output | 1 | Read port B out-of-frame flag |
| wr_en | input | 1 | Write request |
| wr_idx | input | 7 | Write logical index |
| wr_data | input | 64 | Write data |
| wr_nat | input | 1 | NaT flag to store with the write |
| wr_bad | output | 1 | Current write targets an out-of-frame register |
| fm_load | input | 1 | Load the frame marker from fm_value |
| fm_value | input | 38 | New frame-marker word |
| rot_step | input | 1 | Step the general-register rename base |
| fm_out | output | 38 | Current frame-marker word |

## Verification
The hardest case to reach from the ports is a renamed access that depends on state built up over several cycles. The values must sit at known physical slots before the base moves, and they can only be placed there through the renaming itself. The stimulus first writes the rotating region while the base is zero, so that logical and physical numbers match. It then moves the base by direct loads and by rotate steps, including the wrap from 0, and reads back the expected values. It also writes through a nonzero base and reads the result back with the base cleared. A further sequence presents a write and a frame-marker load in the same cycle, so that the write can only have landed if the old frame marker was used.

// File: rtl/stkrf_pkg.sv
package stkrf_pkg;

  localparam int FM_W = 38;

  typedef struct packed {
    logic [5:0] rrb_pr;
    logic [6:0] rrb_fr;
    logic [6:0] rrb_gr;
    logic [3:0] sor;
    logic [6:0] sol;
    logic [6:0] sof;
  } fm_t;

  // Rotating region size, clamped to the stacked area.
  function automatic logic [7:0] rot_size(input fm_t f, input logic [7:0] nstk);
    logic [7:0] raw;
    raw = {1'b0, f.sor, 3'b000};
    return (raw > nstk) ? nstk : raw;
  endfunction

endpackage

// File: rtl/stkrf_map.sv
module stkrf_map
  import stkrf_pkg::*;
#(
  parameter int NREG  = 128,
  parameter int NGLOB = 32,
  localparam int IW   = $clog2(NREG),
  localparam int CW   = IW + 2
) (
  input  logic [IW-1:0] idx,
  input  fm_t           fm,
  output logic [IW-1:0] phys,
  output logic          bad,
  output logic          zero
);
  localparam logic [7:0]    NSTK = 8'(NREG - NGLOB);
  localparam logic [IW-1:0] GBASE = IW'(NGLOB);

  logic          is_stk;
  logic [CW-1:0] off;
  logic [CW-1:0] rsz;
  logic [CW-1:0] rsz_safe;
  logic [CW-1:0] sum;
  logic [CW-1:0] wrapped;
  logic          in_rot;

  always_comb begin
    is_stk   = (idx >= GBASE);
    off      = CW'(idx) - CW'(GBASE);
    rsz      = CW'(rot_size(fm, NSTK));
    rsz_safe = (rsz == '0) ? CW'(1) : rsz;
    sum      = off + CW'(fm.rrb_gr);
    wrapped  = sum % rsz_safe;
    in_rot   = is_stk && (off < rsz);
    zero     = (idx == '0);
    bad      = is_stk && (off >= CW'(fm.sof));
    if (in_rot) phys = GBASE + IW'(wrapped);
    else        phys = idx;
  end

endmodule

// File: rtl/stkrf_frame.sv
module stkrf_frame
  import stkrf_pkg::*;
#(
  parameter int NREG  = 128,
  parameter int NGLOB = 32
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  fm_t       value,
  input  logic      step,
  output fm_t       fm
);
  localparam logic [7:0] NSTK = 8'(NREG - NGLOB);

  fm_t        fm_q;
  logic [7:0] rsz;
  logic [7:0] base_red;
  logic [6:0] base_next;

  always_comb begin
    rsz       = rot_size(fm_q, NSTK);
    base_red  = (rsz == '0) ? 8'd0 : ({1'b0, fm_q.rrb_gr} % rsz);
    base_next = fm_q.rrb_gr;
    if (rsz != '0) begin
      if (base_red == '0) base_next = 7'(rsz - 8'd1);
      else                base_next = 7'(base_red - 8'd1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fm_q <= '0;
    end else if (load) begin
      fm_q <= value;
    end else if (step) begin
      fm_q.rrb_gr <= base_next;
    end
  end

  assign fm = fm_q;

endmodule

// File: rtl/stkrf_bank.sv
module stkrf_bank #(
  parameter int W    = 64,
  parameter int NREG = 128,
  parameter int NRD  = 2,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [IW-1:0]            wa,
  input  logic [W-1:0]             wd,
  input  logic                     wnat,
  input  logic [NRD-1:0][IW-1:0]   ra,
  output logic [NRD-1:0][W-1:0]    rdata,
  output logic [NRD-1:0]           rnat
);
  logic [NREG-1:0] nat_q;

  always_ff @(posedge clk) begin
    if (rst) nat_q <= '0;
    else if (we) nat_q[wa] <= wnat;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_port
    // One RAM copy per read port keeps each copy simple dual-port.
    logic [W-1:0] mem [NREG];
    logic [W-1:0] q;
    logic         nq;

    always_ff @(posedge clk) begin
      if (we) mem[wa] <= wd;
      q <= mem[ra[p]];
    end

    always_ff @(posedge clk) begin
      if (rst) nq <= 1'b0;
      else     nq <= nat_q[ra[p]];
    end

    assign rdata[p] = q;
    assign rnat[p]  = nq;
  end

endmodule

// File: rtl/stkrf_top.sv
module stkrf_top
  import stkrf_pkg::*;
#(
  parameter int W     = 64,
  parameter int NREG  = 128,
  parameter int NGLOB = 32,
  localparam int IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] rd_a_idx,
  output logic [W-1:0]  rd_a_data,
  output logic          rd_a_nat,
  output logic          rd_a_bad,
  input  logic [IW-1:0] rd_b_idx,
  output logic [W-1:0]  rd_b_data,
  output logic          rd_b_nat,
  output logic          rd_b_bad,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic          wr_nat,
  output logic          wr_bad,
  input  logic          fm_load,
  input  logic [FM_W-1:0] fm_value,
  input  logic          rot_step,
  output logic [FM_W-1:0] fm_out
);
  localparam int NRD  = 2;
  localparam int NACC = NRD + 1;   // read ports then the write port

  fm_t fm;

  stkrf_frame #(.NREG(NREG), .NGLOB(NGLOB)) u_frame (
    .clk   (clk),
    .rst   (rst),
    .load  (fm_load),
    .value (fm_t'(fm_value)),
    .step  (rot_step),
    .fm    (fm)
  );

  logic [NACC-1:0][IW-1:0] lidx;
  logic [NACC-1:0][IW-1:0] pidx;
  logic [NACC-1:0]         acc_bad;
  logic [NACC-1:0]         acc_zero;

  assign lidx[0] = rd_a_idx;
  assign lidx[1] = rd_b_idx;
  assign lidx[2] = wr_idx;

  for (genvar i = 0; i < NACC; i++) begin : g_map
    stkrf_map #(.NREG(NREG), .NGLOB(NGLOB)) u_map (
      .idx  (lidx[i]),
      .fm   (fm),
      .phys (pidx[i]),
      .bad  (acc_bad[i]),
      .zero (acc_zero[i])
    );
  end

  logic                   we;
  logic [NRD-1:0][IW-1:0] ra;
  logic [NRD-1:0][W-1:0]  ram_q;
  logic [NRD-1:0]         ram_nat;

  assign we     = wr_en && !acc_bad[NRD] && !acc_zero[NRD];
  assign wr_bad = wr_en && acc_bad[NRD];

  for (genvar p = 0; p < NRD; p++) begin : g_ra
    assign ra[p] = pidx[p];
  end

  stkrf_bank #(.W(W), .NREG(NREG), .NRD(NRD)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (we),
    .wa    (pidx[NRD]),
    .wd    (wr_data),
    .wnat  (wr_nat),
    .ra    (ra),
    .rdata (ram_q),
    .rnat  (ram_nat)
  );

  logic [NRD-1:0]        bad_q;
  logic [NRD-1:0]        zero_q;
  logic [NRD-1:0][W-1:0] out_d;
  logic [NRD-1:0]        out_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      bad_q  <= '0;
      zero_q <= '0;
    end else begin
      bad_q  <= acc_bad[NRD-1:0];
      zero_q <= acc_zero[NRD-1:0];
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_out
    assign out_d[p] = (bad_q[p] || zero_q[p]) ? '0 : ram_q[p];
    assign out_n[p] = bad_q[p] || (!zero_q[p] && ram_nat[p]);
  end

  assign rd_a_data = out_d[0];
  assign rd_a_nat  = out_n[0];
  assign rd_a_bad  = bad_q[0];
  assign rd_b_data = out_d[1];
  assign rd_b_nat  = out_n[1];
  assign rd_b_bad  = bad_q[1];
  assign fm_out    = fm;

endmodule

// File: rtl/stkrf_chk.sv
module stkrf_chk #(
  parameter int W     = 64,
  parameter int NREG  = 128,
  parameter int NGLOB = 32,
  localparam int IW   = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst,
  input logic [IW-1:0] rd_a_idx,
  input logic [W-1:0]  rd_a_data,
  input logic          rd_a_nat,
  input logic          rd_a_bad,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx,
  input logic          wr_bad,
  input logic          fm_load,
  input logic [37:0]   fm_value,
  input logic          rot_step,
  input logic [37:0]   fm_out
);
  localparam logic [IW-1:0] GB = IW'(NGLOB);

  p_zero_read_r2: assert property (@(posedge clk) disable iff (rst)
    rd_a_idx == '0 |=> (rd_a_data == '0) && !rd_a_nat && !rd_a_bad);

  p_bad_read_r4: assert property (@(posedge clk) disable iff (rst)
    rd_a_bad |-> (rd_a_data == '0) && rd_a_nat);

  p_wr_bad_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx >= GB && ({1'b0, wr_idx - GB} >= {1'b0, fm_out[6:0]})) |-> wr_bad);

  p_global_ok_r8: assert property (@(posedge clk) disable iff (rst)
    rd_a_idx < GB |=> !rd_a_bad);

  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    fm_load |=> fm_out == $past(fm_value));

  p_rot_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (rot_step && !fm_load) |=> (fm_out[37:25] == $past(fm_out[37:25])) &&
                                (fm_out[17:0] == $past(fm_out[17:0])));

  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!rot_step && !fm_load) |=> $stable(fm_out));

endmodule

bind stkrf_top stkrf_chk #(.W(W), .NREG(NREG), .NGLOB(NGLOB)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_a_idx  (rd_a_idx),
  .rd_a_data (rd_a_data),
  .rd_a_nat  (rd_a_nat),
  .rd_a_bad  (rd_a_bad),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_bad    (wr_bad),
  .fm_load   (fm_load),
  .fm_value  (fm_value),
  .rot_step  (rot_step),
  .fm_out    (fm_out)
);

// File: tb/stkrf_top_test.sv
module stkrf_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [63:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        rd_a_nat, rd_a_bad, rd_b_nat, rd_b_bad;
  logic        wr_en = 1'b0, wr_nat = 1'b0, wr_bad;
  logic        fm_load = 1'b0, rot_step = 1'b0;
  logic [37:0] fm_value = '0, fm_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stkrf_top uut (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_a_nat(rd_a_nat), .rd_a_bad(rd_a_bad),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .rd_b_nat(rd_b_nat), .rd_b_bad(rd_b_bad),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_nat(wr_nat), .wr_bad(wr_bad),
    .fm_load(fm_load), .fm_value(fm_value), .rot_step(rot_step), .fm_out(fm_out)
  );

  function automatic logic [37:0] mkfm(input int sof, input int sol, input int sor,
                                        input int gr, input int fr, input int pr);
    return {6'(pr), 7'(fr), 7'(gr), 4'(sor), 7'(sol), 7'(sof)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [6:0] a, input logic [6:0] b);
    @(negedge clk);
    rd_a_idx = a; rd_b_idx = b;
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [6:0] i, input logic [63:0] d, input logic n, output logic bad);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_data = d; wr_nat = n;
    #1 bad = wr_bad;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic ldfm(input logic [37:0] v);
    @(negedge clk);
    fm_load = 1'b1; fm_value = v;
    @(posedge clk); #1;
    fm_load = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    rot_step = 1'b1;
    @(posedge clk); #1;
    rot_step = 1'b0;
  endtask

  task automatic t_reset();
    chk(fm_out == '0, "R1 frame marker", 64'(fm_out), 0);
    rd(7'd5, 7'd31);
    chk(rd_a_nat == 1'b0, "R1 nat clear a", 64'(rd_a_nat), 0);
    chk(rd_b_nat == 1'b0, "R1 nat clear b", 64'(rd_b_nat), 0);
  endtask

  task automatic t_zero();
    logic b;
    wr(7'd0, 64'hDEAD, 1'b1, b);
    rd(7'd0, 7'd0);
    chk(rd_a_data == 0 && !rd_a_nat, "R2 reg0 a", rd_a_data, 0);
    chk(rd_b_data == 0 && !rd_b_nat, "R2 reg0 b", rd_b_data, 0);
  endtask

  task automatic t_global();
    logic b;
    wr(7'd7, 64'h1111_2222_3333_4444, 1'b1, b);
    chk(b == 1'b0, "R8 global write not bad", 64'(b), 0);
    wr(7'd9, 64'h55, 1'b0, b);
    rd(7'd7, 7'd9);
    chk(rd_a_data == 64'h1111_2222_3333_4444, "R3 data a", rd_a_data, 64'h1111_2222_3333_4444);
    chk(rd_a_nat == 1'b1, "R3 nat a", 64'(rd_a_nat), 1);
    chk(rd_b_data == 64'h55 && !rd_b_nat, "R3 data b", rd_b_data, 64'h55);
    // same-cycle read returns old value
    @(negedge clk);
    rd_a_idx = 7'd9; wr_en = 1'b1; wr_idx = 7'd9; wr_data = 64'h66; wr_nat = 1'b0;
    @(posedge clk); #1; wr_en = 1'b0;
    chk(rd_a_data == 64'h55, "R3 read-first", rd_a_data, 64'h55);
    rd(7'd9, 7'd9);
    chk(rd_a_data == 64'h66, "R3 new value", rd_a_data, 64'h66);
  endtask

  task automatic t_bounds();
    logic b;
    ldfm(mkfm(10, 4, 0, 0, 0, 0));
    wr(7'd41, 64'h41, 1'b0, b);
    chk(b == 1'b0, "R4 last in-frame write", 64'(b), 0);
    wr(7'd42, 64'h42, 1'b0, b);
    chk(b == 1'b1, "R4 out-of-frame wr_bad", 64'(b), 1);
    rd(7'd41, 7'd42);
    chk(rd_a_data == 64'h41 && !rd_a_bad, "R4 in-frame read", rd_a_data, 64'h41);
    chk(rd_b_bad && rd_b_nat && rd_b_data == 0, "R4 out-of-frame read", rd_b_data, 0);
    ldfm(mkfm(11, 0, 0, 0, 0, 0));
    rd(7'd42, 7'd42);
    chk(!rd_a_bad && rd_a_data != 64'h42, "R4 dropped write", rd_a_data, 0);
    ldfm(mkfm(0, 0, 0, 0, 0, 0));
    rd(7'd32, 7'd31);
    chk(rd_a_bad == 1'b1, "R4 empty frame", 64'(rd_a_bad), 1);
    chk(!rd_b_bad, "R8 global with empty frame", 64'(rd_b_bad), 0);
  endtask

  task automatic t_rotate();
    logic b;
    ldfm(mkfm(16, 8, 1, 0, 0, 0));
    for (int k = 0; k < 9; k++) wr(7'(32 + k), 64'(100 + k), 1'b0, b);
    ldfm(mkfm(16, 8, 1, 3, 0, 0));
    rd(7'd32, 7'd37);
    chk(rd_a_data == 64'd103, "R6 base3 r32", rd_a_data, 103);
    chk(rd_b_data == 64'd100, "R6 base3 r37 wraps", rd_b_data, 100);
    rd(7'd40, 7'd9);
    chk(rd_a_data == 64'd108, "R6 beyond rotating", rd_a_data, 108);
    chk(rd_b_data == 64'h66, "R8 global not renamed", rd_b_data, 64'h66);
    ldfm(mkfm(16, 8, 1, 0, 5, 9));
    step();
    chk(fm_out == mkfm(16, 8, 1, 7, 5, 9), "R7 wrap step", 64'(fm_out), 64'(mkfm(16, 8, 1, 7, 5, 9)));
    rd(7'd32, 7'd33);
    chk(rd_a_data == 64'd107, "R6 after step r32", rd_a_data, 107);
    step();
    chk(fm_out[24:18] == 7'd6, "R7 second step", 64'(fm_out[24:18]), 6);
    ldfm(mkfm(16, 8, 1, 7, 0, 0));
    wr(7'd33, 64'hBEEF, 1'b1, b);
    ldfm(mkfm(16, 8, 1, 0, 0, 0));
    rd(7'd32, 7'd32);
    chk(rd_a_data == 64'hBEEF && rd_a_nat, "R6 renamed write", rd_a_data, 64'hBEEF);
    ldfm(mkfm(16, 0, 0, 4, 0, 0));
    step();
    chk(fm_out[24:18] == 7'd4, "R7 sor zero no step", 64'(fm_out[24:18]), 4);
    // load and step together
    @(negedge clk);
    fm_load = 1'b1; rot_step = 1'b1; fm_value = mkfm(20, 0, 2, 1, 0, 0);
    @(posedge clk); #1; fm_load = 1'b0; rot_step = 1'b0;
    chk(fm_out == mkfm(20, 0, 2, 1, 0, 0), "R7 load wins", 64'(fm_out), 64'(mkfm(20, 0, 2, 1, 0, 0)));
  endtask

  task automatic t_same_cycle();
    ldfm(mkfm(16, 0, 0, 0, 0, 0));
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 7'd32; wr_data = 64'hAAAA; wr_nat = 1'b0;
    fm_load = 1'b1; fm_value = mkfm(0, 0, 0, 0, 0, 0);
    @(posedge clk); #1; wr_en = 1'b0; fm_load = 1'b0;
    rd(7'd32, 7'd32);
    chk(rd_a_bad == 1'b1, "R9 new frame governs", 64'(rd_a_bad), 1);
    ldfm(mkfm(16, 0, 0, 0, 0, 0));
    rd(7'd32, 7'd32);
    chk(rd_a_data == 64'hAAAA, "R9 write used old frame", rd_a_data, 64'hAAAA);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_zero();
    t_global();
    t_bounds();
    t_rotate();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule